// File: doc/BRIEF.md
# Interrupt Event Manager

The block collects a parameterised number of event sources into one interrupt line. Each source is given a kind at elaboration time through a parameter vector: a pulse source latches any cycle in which its trigger is high, a process source latches the cycle in which its busy signal falls, and a level source simply mirrors its trigger. Software sees three registers through a small register port, a status word, a pending word and an enable word, with one bit per source in each. The interrupt output is raised while any enabled source has an event pending.

Each latching source is a two-state machine. `LAT_IDLE` means nothing is pending. The transition `LAT_IDLE -> LAT_ARMED` is named *capture* and is taken when the source's set condition holds. The transition `LAT_ARMED -> LAT_IDLE` is named *release* and is taken when software writes 1 to the source's pending bit in a cycle with no new set condition. In every other case the machine stays where it is: *hold* in `LAT_ARMED`, *wait* in `LAT_IDLE`. A level source never leaves `LAT_IDLE`, and its pending bit is taken straight from the trigger. Read data is registered: it appears one cycle after the address is presented.

Top module: `irq_event_mgr`

## Requirements
- R1: A pulse source becomes pending on the clock edge after any cycle in which its trigger is high. It stays pending after the trigger drops until software clears it.
- R2: A process source becomes pending on the clock edge after its trigger goes from 1 to 0. While its trigger stays high, or when it rises, the pending bit does not change.
- R3: The pending bit of a level source equals its trigger at all times. Writing 1 to that bit has no effect.
- R4: A status bit reads the current trigger value for process and level sources and always reads 0 for pulse sources.
- R5: Writing to the pending register clears each pulse or process source whose data bit is 1. Bits written as 0 leave their sources unchanged.
- R6: The enable register can be written and read back, and it resets to all zeros.
- R7: The interrupt output is high exactly when at least one source is both pending and enabled.
- R8: If a source's set condition occurs in the same cycle as a software clear of that source, the source stays pending.
- R9: After reset no pulse or process source is pending.
- R10: The register address selects the register: 0 is status, 1 is pending, 2 is enable and 3 reads zero. Bit i of each register belongs to source i, and bits above the source count read 0. Read data appears on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_trig | input | N_SRC | One trigger line per source |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Combined interrupt line |

## Verification
The assertions check several rules on every cycle. A pulse trigger always leads to a pending bit on the next edge. A pending bit is only dropped after a clear. A falling process trigger always sets the pending bit. A set that meets a clear in the same cycle wins. A write to the enable register lands. The interrupt stays low while nothing is enabled. Other behaviour is only shown by the bench's scenarios. These include the register map and its one-cycle read latency, the way status reads for each source kind, the fact that a clear of a level source has no effect, and the combined interrupt line as several sources are set and cleared one at a time.

// File: rtl/evtm_pkg.sv
package evtm_pkg;

    typedef enum logic [1:0] {
        KIND_PULSE = 2'd0,
        KIND_PROC  = 2'd1,
        KIND_LEVEL = 2'd2
    } src_kind_e;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_PEND   = 2'd1,
        REG_ENABLE = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LAT_IDLE  = 1'b0,
        LAT_ARMED = 1'b1
    } lat_state_e;

endpackage

// File: rtl/evtm_source.sv
module evtm_source
    import evtm_pkg::*;
#(
    parameter logic [1:0] KIND = KIND_PULSE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic clr_i,
    output logic pend_o,
    output logic stat_o
);

    lat_state_e st_q, st_d;
    logic       trig_q;
    logic       set_w;

    // previous trigger sample, used for falling-edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end

    always_comb begin
        case (KIND)
            KIND_PULSE: set_w = trig_i;
            KIND_PROC:  set_w = trig_q & ~trig_i;
            default:    set_w = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LAT_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic: capture / hold / release / wait
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LAT_IDLE:  if (set_w)            st_d = LAT_ARMED;
            LAT_ARMED: if (clr_i && !set_w)  st_d = LAT_IDLE;
            default:                         st_d = LAT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        if (KIND == KIND_LEVEL) pend_o = trig_i;
        else                    pend_o = (st_q == LAT_ARMED);
        if (KIND == KIND_PULSE) stat_o = 1'b0;
        else                    stat_o = trig_i;
    end

    generate
        if (KIND == KIND_PULSE) begin : g_pulse_chk
            p_pulse_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
                trig_i |=> pend_o);
            p_pulse_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_o && !clr_i) |=> pend_o);
            p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (trig_i && clr_i) |=> pend_o);
            p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_o && clr_i && !trig_i) |=> !pend_o);
        end
        if (KIND == KIND_PROC) begin : g_proc_chk
            p_proc_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $fell(trig_i)) |=> pend_o);
            p_proc_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_o && !clr_i) |=> pend_o);
        end
    endgenerate

endmodule

// File: rtl/evtm_regfile.sv
module evtm_regfile
    import evtm_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N_SRC-1:0]  stat_i,
    input  logic [N_SRC-1:0]  pend_i,
    output logic [N_SRC-1:0]  clr_o,
    output logic [N_SRC-1:0]  en_o,
    output logic [DATA_W-1:0] rdata_o
);

    reg_sel_e          sel;
    logic [N_SRC-1:0]  en_q;
    logic [DATA_W-1:0] rd_next;

    assign sel  = reg_sel_e'(addr_i);
    assign en_o = en_q;

    always_comb begin
        clr_o = '0;
        if (we_i && sel == REG_PEND) clr_o = wdata_i[N_SRC-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          en_q <= '0;
        else if (we_i && sel == REG_ENABLE)  en_q <= wdata_i[N_SRC-1:0];
    end

    always_comb begin
        unique case (sel)
            REG_STATUS: rd_next = DATA_W'(stat_i);
            REG_PEND:   rd_next = DATA_W'(pend_i);
            REG_ENABLE: rd_next = DATA_W'(en_q);
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= rd_next;
    end

    p_enable_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == REG_ENABLE) |=> (en_o == $past(wdata_i[N_SRC-1:0])));

endmodule

// File: rtl/evtm_combine.sv
module evtm_combine #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] en_i,
    output logic             irq_o
);

    assign irq_o = |(pend_i & en_i);

    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> !irq_o);
    p_irq_needs_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_i != '0));

endmodule

// File: rtl/irq_event_mgr.sv
module irq_event_mgr
    import evtm_pkg::*;
#(
    parameter int               N_SRC  = 4,
    parameter int               DATA_W = 8,
    parameter logic [2*N_SRC-1:0] KINDS = 8'b00_10_01_00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_trig,
    input  logic [1:0]        reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [N_SRC-1:0] pend_w;
    logic [N_SRC-1:0] stat_w;
    logic [N_SRC-1:0] clr_w;
    logic [N_SRC-1:0] en_w;

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            evtm_source #(
                .KIND (KINDS[2*i +: 2])
            ) u_src (
                .clk    (clk),
                .rst_n  (rst_n),
                .trig_i (src_trig[i]),
                .clr_i  (clr_w[i]),
                .pend_o (pend_w[i]),
                .stat_o (stat_w[i])
            );
        end
    endgenerate

    evtm_regfile #(
        .N_SRC  (N_SRC),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr),
        .we_i    (reg_we),
        .wdata_i (reg_wdata),
        .stat_i  (stat_w),
        .pend_i  (pend_w),
        .clr_o   (clr_w),
        .en_o    (en_w),
        .rdata_o (reg_rdata)
    );

    evtm_combine #(
        .N_SRC (N_SRC)
    ) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_w),
        .en_i   (en_w),
        .irq_o  (irq)
    );

endmodule

// File: tb/irq_event_mgr_bench.sv
`timescale 1ns/1ps
module irq_event_mgr_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_trig = '0;
    logic [1:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    int         due_q[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_event_mgr u_irq_event_mgr (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_trig  (src_trig),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
    endtask

    // driver: present address, push expected read data for the monitor
    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        reg_addr = a;
        due_q.push_back(cyc + 1);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        tick();
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_tests++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq=%b expected %b", tag, irq, e);
        end
    endtask

    // monitor: pop expected items when their read data is due
    initial begin
        forever begin
            @(negedge clk);
            if (due_q.size() > 0 && due_q[0] <= cyc) begin
                int         d;
                logic [7:0] e;
                string      t;
                d = due_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_tests++;
                if (reg_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h expected %h (due %0d)", t, reg_rdata, e, d);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // reset state
        rd(2'd0, 8'h00, "R9 status after reset");
        rd(2'd1, 8'h00, "R9 pending after reset");
        rd(2'd2, 8'h00, "R6 enable after reset");
        chk_irq(1'b0, "R7 irq after reset");

        // pulse source 0
        src_trig = 4'b0001; tick();
        src_trig = 4'b0000; tick();
        rd(2'd1, 8'h01, "R1 pulse latched");
        repeat (3) tick();
        rd(2'd1, 8'h01, "R1 pulse sticky");
        rd(2'd0, 8'h00, "R4 pulse status zero");
        chk_irq(1'b0, "R7 pending but masked");

        wr(2'd2, 8'h01);
        chk_irq(1'b1, "R7 enabled pending");
        rd(2'd2, 8'h01, "R6 enable readback");

        wr(2'd1, 8'h00);
        rd(2'd1, 8'h01, "R5 write zero no effect");
        wr(2'd1, 8'h01);
        rd(2'd1, 8'h00, "R5 write one clears");
        chk_irq(1'b0, "R5 irq drops after clear");

        // process source 1
        src_trig = 4'b0010; tick();
        rd(2'd1, 8'h00, "R2 no set while busy");
        rd(2'd0, 8'h02, "R4 process status high");
        src_trig = 4'b0000; tick();
        rd(2'd1, 8'h02, "R2 falling edge sets");
        rd(2'd0, 8'h00, "R4 process status low");
        wr(2'd1, 8'h02);
        rd(2'd1, 8'h00, "R5 clear process");

        // level source 2
        src_trig = 4'b0100;
        rd(2'd1, 8'h04, "R3 level pending");
        rd(2'd0, 8'h04, "R4 level status");
        wr(2'd1, 8'h04);
        rd(2'd1, 8'h04, "R3 clear ignored");
        wr(2'd2, 8'h04);
        chk_irq(1'b1, "R7 level irq");
        src_trig = 4'b0000; tick();
        chk_irq(1'b0, "R3 irq follows level");
        rd(2'd1, 8'h00, "R3 level drop");

        // set and clear in same cycle, pulse source 3
        src_trig = 4'b1000; tick();
        wr(2'd1, 8'h08);
        src_trig = 4'b0000;
        rd(2'd1, 8'h08, "R8 set beats clear");
        wr(2'd1, 8'h08);
        rd(2'd1, 8'h00, "R8 later clear works");

        rd(2'd3, 8'h00, "R10 spare address");

        // status with several kinds active
        src_trig = 4'b0111; tick();
        rd(2'd0, 8'h06, "R4 status mixed");
        src_trig = 4'b0000; tick();
        rd(2'd1, 8'h03, "R10 pending bit positions");
        wr(2'd1, 8'h03);

        // multiple pending sources
        wr(2'd2, 8'h0F);
        src_trig = 4'b1001; tick();
        src_trig = 4'b0000;
        chk_irq(1'b1, "R7 two pending");
        wr(2'd1, 8'h01);
        chk_irq(1'b1, "R7 one still pending");
        rd(2'd1, 8'h08, "R10 pending register map");
        wr(2'd1, 8'h08);
        chk_irq(1'b0, "R7 all cleared");
        rd(2'd2, 8'h0F, "R10 enable register map");

        while (due_q.size() > 0) tick();
        tick();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule